// File: doc/BRIEF.md
# Stipple and Block-Transfer Raster Engine

This block is a small raster engine that sits behind two memory-mapped address windows of a byte-per-pixel frame buffer with a fixed line pitch of 1024 pixels. Software performs each drawing operation with two 32-bit bus writes. The first write, with address bit 2 clear, loads a colour/source latch. The second write, with address bit 2 set, carries the destination pixel address in its bus address and an operand in its data word. That second write starts the operation.

A separate window-select input picks one of two modes. In stipple mode the operand is a 32-bit mask: each set bit writes the latched colour byte to one pixel of a 32-pixel run, and each clear bit leaves its pixel alone. In blit mode the operand packs a source pixel address and a run length of 1 to 32 pixels. A source of all ones fills the run with the latched colour. Any other source copies the run in ascending address order.

The engine reaches frame-buffer memory through a single-port, byte-wide request interface whose read data arrives one cycle after the request. While an operation runs, `busy_o` is high and `bus_ready_o` is low, so further bus accesses wait.

Top module: `raster_eng`

## Requirements
- R1: After reset, `busy_o` is low, `bus_ready_o` is high and `mem_req_o` is low. The colour latch holds zero, so a fill issued before any latch load writes byte 0x00.
- R2: An accepted 32-bit write with bus address bit 2 clear loads data bits 7:0 into the colour latch. It causes no memory access and `busy_o` stays low.
- R3: An accepted 32-bit write with bus address bit 2 set starts an operation. Its destination pixel address is bus address bits 22:3, a 20-bit value.
- R4: In stipple mode, data bit (31-k) set writes the latched colour byte to pixel destination+k, and a clear bit leaves that pixel unchanged. Writes go in ascending k, one memory write per cycle, one per set bit. `busy_o` is high for exactly as many cycles as there are set bits, and a zero mask starts no memory access.
- R5: In blit mode, data bits 28:24 plus one give the run length, from 1 to 32. Data bits 31:29 are ignored.
- R6: In blit mode, a source field (data bits 23:0) equal to 0xFFFFFF fills the run with the latched colour byte, one write per cycle and no reads.
- R7: In blit mode, any other source copies pixel source+i to destination+i for i rising from 0. Each pixel takes one read cycle followed by one write cycle, so a run of L pixels keeps `busy_o` high for 2L cycles. When the destination lies above an overlapping source, bytes already written are re-read.
- R8: Every read from either window is accepted at once, returns 0, and starts nothing.
- R9: A write whose `bus_size_i` is not 2'b10 (32-bit) is accepted but ignored: it does not change the latch and does not start an operation.
- R10: While `busy_o` is high, `bus_ready_o` is low and no bus access is taken. An access offered meanwhile is taken only after the operation completes.
- R11: `bus_win_i` = 0 selects stipple mode and `bus_win_i` = 1 selects blit mode, for the same address and data.
- R12: Destination and source pixel addresses advance modulo 2^20, so a run crossing 0xFFFFF continues at 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Access size, 2'b10 = 32-bit |
| bus_win_i | input | 1 | Window hit: 0 = stipple, 1 = blit |
| bus_addr_i | input | 23 | Byte address within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_ready_o | output | 1 | Access taken this cycle when high with valid |
| bus_rdata_o | output | 32 | Read data, always zero |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Frame-buffer access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Pixel address |
| mem_wdata_o | output | 8 | Pixel write data |
| mem_rdata_i | input | 8 | Pixel read data, valid the cycle after a read request |

## Verification
A corrupted mask or run counter shows up as a wrong write count and a wrong `busy_o` duration as soon as the operation ends. Every run is therefore timed in cycles and counted in accesses, in addition to comparing pixel contents. A latch that changes while an operation is still running appears as mixed colours within a single fill run. An off-by-one in the copy sequencing appears immediately in the upward-overlapping copy, whose expected result depends on bytes being re-read. Address wrap and the ignored upper length bits are checked from the logged write addresses rather than memory contents.

// File: rtl/raster_eng_pkg.sv
package raster_eng_pkg;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [1:0] {
    BL_IDLE,
    BL_FILL,
    BL_RD,
    BL_WR
  } blit_st_e;
endpackage

// File: rtl/raster_eng_dec.sv
module raster_eng_dec
  import raster_eng_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int DATA_W = 32,
  parameter int CLR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [PIX_W+2:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              ready_o,
  output logic              start_o,
  output logic [PIX_W-1:0]  dest_o,
  output logic [DATA_W-1:0] opnd_o,
  output logic [CLR_W-1:0]  colour_o
);
  logic             take;
  logic             word_wr;
  logic [CLR_W-1:0] colour_r;
  logic             unused_bits;

  assign ready_o = !busy_i;
  assign take    = valid_i && ready_o;
  assign word_wr = take && write_i && (size_i == SIZE_WORD);
  assign start_o = word_wr && addr_i[2];
  assign dest_o  = addr_i[PIX_W+2:3];
  assign opnd_o  = wdata_i;
  assign colour_o = colour_r;
  assign unused_bits = ^addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) colour_r <= '0;
    else if (word_wr && !addr_i[2]) colour_r <= wdata_i[CLR_W-1:0];
  end

  // R9: a narrow access must never reach the latch
  a_r9_narrow_keeps_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && write_i && size_i != SIZE_WORD) |=> $stable(colour_r));
endmodule

// File: rtl/raster_eng_stip.sv
module raster_eng_stip #(
  parameter int PIX_W  = 20,
  parameter int MASK_W = 32,
  parameter int CLR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PIX_W-1:0]  dest_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [CLR_W-1:0]  colour_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [PIX_W-1:0]  addr_o,
  output logic [CLR_W-1:0]  wdata_o
);
  localparam int OFF_W = $clog2(MASK_W);

  logic [MASK_W-1:0] mask_r;
  logic [PIX_W-1:0]  dest_r;
  logic [CLR_W-1:0]  colour_r;
  logic [OFF_W-1:0]  top_idx;
  logic [OFF_W-1:0]  off;

  // highest set bit is served first -> lowest pixel offset first
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (mask_r[i]) top_idx = OFF_W'(i);
    end
  end

  assign off     = OFF_W'(MASK_W - 1) - top_idx;
  assign busy_o  = |mask_r;
  assign req_o   = busy_o;
  assign addr_o  = dest_r + {{(PIX_W-OFF_W){1'b0}}, off};
  assign wdata_o = colour_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_r   <= '0;
      dest_r   <= '0;
      colour_r <= '0;
    end else if (start_i) begin
      mask_r   <= mask_i;
      dest_r   <= dest_i;
      colour_r <= colour_i;
    end else if (busy_o) begin
      mask_r[top_idx] <= 1'b0;
    end
  end

  // R4: exactly one mask bit retired per write cycle
  a_r4_one_bit_per_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> ($countones(mask_r) + 1 == $countones($past(mask_r))));
  // R4: pixel offsets rise within an operation
  a_r4_ascending_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o) && !$past(start_i)) |-> (off > $past(off)));
endmodule

// File: rtl/raster_eng_blit.sv
module raster_eng_blit
  import raster_eng_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 24,
  parameter int LEN_W  = 5,
  parameter int CLR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PIX_W-1:0]  dest_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [CLR_W-1:0]  colour_i,
  output logic              busy_o,
  output logic              req_o,
  output logic              we_o,
  output logic [PIX_W-1:0]  addr_o,
  output logic [CLR_W-1:0]  wdata_o,
  input  logic [CLR_W-1:0]  rdata_i
);
  blit_st_e          st_r;
  logic [PIX_W-1:0]  src_r;
  logic [PIX_W-1:0]  dst_r;
  logic [LEN_W-1:0]  cnt_r;
  logic [LEN_W-1:0]  last_r;
  logic [CLR_W-1:0]  colour_r;
  logic [PIX_W-1:0]  cnt_x;
  logic              is_fill;
  logic              last;
  logic              unused_bits;

  assign is_fill = &opnd_i[SRC_W-1:0];
  assign cnt_x   = {{(PIX_W-LEN_W){1'b0}}, cnt_r};
  assign last    = (cnt_r == last_r);
  assign unused_bits = ^{opnd_i[DATA_W-1:SRC_W+LEN_W], opnd_i[SRC_W-1:PIX_W]};

  assign busy_o  = (st_r != BL_IDLE);
  assign req_o   = busy_o;
  assign we_o    = (st_r == BL_FILL) || (st_r == BL_WR);
  assign addr_o  = (st_r == BL_RD) ? (src_r + cnt_x) : (dst_r + cnt_x);
  assign wdata_o = (st_r == BL_WR) ? rdata_i : colour_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_r     <= BL_IDLE;
      src_r    <= '0;
      dst_r    <= '0;
      cnt_r    <= '0;
      last_r   <= '0;
      colour_r <= '0;
    end else begin
      case (st_r)
        BL_IDLE: if (start_i) begin
          st_r     <= is_fill ? BL_FILL : BL_RD;
          src_r    <= opnd_i[PIX_W-1:0];
          dst_r    <= dest_i;
          cnt_r    <= '0;
          last_r   <= opnd_i[SRC_W+LEN_W-1:SRC_W];
          colour_r <= colour_i;
        end
        BL_FILL: begin
          if (last) st_r <= BL_IDLE;
          else cnt_r <= cnt_r + 1'b1;
        end
        BL_RD: st_r <= BL_WR;
        BL_WR: begin
          if (last) st_r <= BL_IDLE;
          else begin
            cnt_r <= cnt_r + 1'b1;
            st_r  <= BL_RD;
          end
        end
        default: st_r <= BL_IDLE;
      endcase
    end
  end

  // R7: every read is followed by its write
  a_r7_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_r == BL_RD) |=> (st_r == BL_WR));
  // R7: a copy write always carries data read the cycle before
  a_r7_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_r == BL_WR) |-> $past(req_o && !we_o));
  // R5: the run counter never passes the requested length
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_r <= last_r));
endmodule

// File: rtl/raster_eng.sv
module raster_eng
  import raster_eng_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 24,
  parameter int LEN_W  = 5,
  parameter int CLR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_size_i,
  input  logic              bus_win_i,
  input  logic [PIX_W+2:0]  bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ready_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PIX_W-1:0]  mem_addr_o,
  output logic [CLR_W-1:0]  mem_wdata_o,
  input  logic [CLR_W-1:0]  mem_rdata_i
);
  logic              start;
  logic [PIX_W-1:0]  dest;
  logic [DATA_W-1:0] opnd;
  logic [CLR_W-1:0]  colour;
  logic              s_busy, s_req;
  logic [PIX_W-1:0]  s_addr;
  logic [CLR_W-1:0]  s_wdata;
  logic              b_busy, b_req, b_we;
  logic [PIX_W-1:0]  b_addr;
  logic [CLR_W-1:0]  b_wdata;

  assign busy_o      = s_busy || b_busy;
  assign bus_rdata_o = '0;

  raster_eng_dec #(.PIX_W(PIX_W), .DATA_W(DATA_W), .CLR_W(CLR_W)) u_dec (
    .clk_i, .rst_ni,
    .valid_i (bus_valid_i),
    .write_i (bus_write_i),
    .size_i  (bus_size_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .busy_i  (busy_o),
    .ready_o (bus_ready_o),
    .start_o (start),
    .dest_o  (dest),
    .opnd_o  (opnd),
    .colour_o(colour)
  );

  raster_eng_stip #(.PIX_W(PIX_W), .MASK_W(DATA_W), .CLR_W(CLR_W)) u_stip (
    .clk_i, .rst_ni,
    .start_i (start && !bus_win_i),
    .dest_i  (dest),
    .mask_i  (opnd),
    .colour_i(colour),
    .busy_o  (s_busy),
    .req_o   (s_req),
    .addr_o  (s_addr),
    .wdata_o (s_wdata)
  );

  raster_eng_blit #(.PIX_W(PIX_W), .DATA_W(DATA_W), .SRC_W(SRC_W),
                    .LEN_W(LEN_W), .CLR_W(CLR_W)) u_blit (
    .clk_i, .rst_ni,
    .start_i (start && bus_win_i),
    .dest_i  (dest),
    .opnd_i  (opnd),
    .colour_i(colour),
    .busy_o  (b_busy),
    .req_o   (b_req),
    .we_o    (b_we),
    .addr_o  (b_addr),
    .wdata_o (b_wdata),
    .rdata_i (mem_rdata_i)
  );

  assign mem_req_o   = s_req || b_req;
  assign mem_we_o    = s_req || b_we;
  assign mem_addr_o  = s_req ? s_addr : b_addr;
  assign mem_wdata_o = s_req ? s_wdata : b_wdata;

  // R2: latch loads never start work
  a_r2_latch_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_ready_o && bus_write_i && !bus_addr_i[2]) |=> !busy_o);
  // R8: reads never start work
  a_r8_read_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_ready_o && !bus_write_i) |=> !busy_o);
  // R10: busy only rises from an accepted word trigger write
  a_r10_busy_from_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(bus_valid_i && bus_ready_o && bus_write_i &&
                            bus_addr_i[2] && bus_size_i == SIZE_WORD));
  // R11: the two engines never run together
  a_r11_one_engine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_busy && b_busy));
endmodule

// File: tb/raster_eng_tb.sv
module raster_eng_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, win = 1'b0;
  logic [1:0]  size = 2'b10;
  logic [22:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready, busy, mreq, mwe;
  logic [31:0] rdata;
  logic [19:0] maddr;
  logic [7:0]  mwd;
  logic [7:0]  mrd = '0;

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_rd = 0;
  logic [19:0] wlog [0:63];
  logic [7:0]  mem [0:4095];

  always #2 clk = ~clk;

  raster_eng u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
    .bus_size_i(size), .bus_win_i(win), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_ready_o(ready), .bus_rdata_o(rdata), .busy_o(busy),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwd), .mem_rdata_i(mrd)
  );

  always @(posedge clk) begin
    if (mreq) begin
      if (mwe) begin
        mem[maddr[11:0]] <= mwd;
        if (n_wr < 64) wlog[n_wr] = maddr;
        n_wr = n_wr + 1;
      end else begin
        mrd <= mem[maddr[11:0]];
        n_rd = n_rd + 1;
      end
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    n_wr = 0;
    n_rd = 0;
  endtask

  // issue one access at negedge, held until taken
  task automatic bus_acc(input logic w, input logic wn, input logic [1:0] sz,
                         input logic [22:0] a, input logic [31:0] d);
    valid = 1'b1; wr = w; win = wn; size = sz; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; wr = 1'b0; size = 2'b10;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [22:0] trig(input int dest);
    return 23'((dest << 3) | 4);
  endfunction

  task automatic t_reset();
    int cyc;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 ready", 32'(ready), 1);
    chk("R1 mem_req", 32'(mreq), 0);
    clr_log();
    bus_acc(1, 1, 2'b10, trig(12'h080), 32'h00FF_FFFF);
    wait_idle(cyc);
    chk("R1 fill colour after reset", 32'(mem[12'h080]), 0);
    chk("R1 single write", n_wr, 1);
  endtask

  task automatic t_latch_only();
    int cyc;
    clr_log();
    bus_acc(1, 0, 2'b10, 23'h000100, 32'h1234_56A5);
    chk("R2 busy after latch", 32'(busy), 0);
    wait_idle(cyc);
    chk("R2 no mem access", n_wr + n_rd, 0);
  endtask

  task automatic t_stipple();
    int cyc, k;
    logic [31:0] m;
    m = 32'h04FF_FFFF; // in blit window this would be a 5-pixel fill
    clr_log();
    bus_acc(1, 0, 2'b10, trig(12'h100), m);
    wait_idle(cyc);
    chk("R4 busy cycles", cyc, $countones(m));
    chk("R11 stipple write count", n_wr, $countones(m));
    chk("R4 no reads", n_rd, 0);
    for (k = 0; k < 32; k++)
      chk("R4 R3 stipple pixel", 32'(mem[12'h100 + k]), m[31-k] ? 32'hA5 : 32'(pat(12'h100 + k)));
    chk("R3 no spill after run", 32'(mem[12'h120]), 32'(pat(12'h120)));
    chk("R4 first write addr", 32'(wlog[0]), 32'h105);
    clr_log();
    bus_acc(1, 0, 2'b10, trig(12'h140), 32'h0);
    chk("R4 zero mask not busy", 32'(busy), 0);
    wait_idle(cyc);
    chk("R4 zero mask writes", n_wr, 0);
  endtask

  task automatic t_fill();
    int cyc, k;
    bus_acc(1, 1, 2'b10, 23'h0, 32'h0000_003C);
    clr_log();
    bus_acc(1, 1, 2'b10, trig(12'h200), 32'hE4FF_FFFF); // len field 4, bits 31:29 set
    wait_idle(cyc);
    chk("R5 length 5", n_wr, 5);
    chk("R6 fill no reads", n_rd, 0);
    chk("R6 fill cycles", cyc, 5);
    for (k = 0; k < 5; k++) chk("R6 fill pixel", 32'(mem[12'h200 + k]), 32'h3C);
    chk("R6 below run", 32'(mem[12'h1FF]), 32'(pat(12'h1FF)));
    chk("R6 above run", 32'(mem[12'h205]), 32'(pat(12'h205)));
    clr_log();
    bus_acc(1, 1, 2'b10, trig(12'h600), 32'h1FFF_FFFF);
    wait_idle(cyc);
    chk("R5 max length 32", n_wr, 32);
    chk("R5 last pixel", 32'(mem[12'h61F]), 32'h3C);
    chk("R5 past max", 32'(mem[12'h620]), 32'(pat(12'h620)));
  endtask

  task automatic t_copy();
    int cyc, k;
    clr_log();
    bus_acc(1, 1, 2'b10, trig(12'h340), 32'h0700_0300);
    wait_idle(cyc);
    chk("R7 copy cycles", cyc, 16);
    chk("R7 reads", n_rd, 8);
    chk("R7 writes", n_wr, 8);
    for (k = 0; k < 8; k++) chk("R7 copy pixel", 32'(mem[12'h340 + k]), 32'(pat(12'h300 + k)));
    chk("R7 past copy", 32'(mem[12'h348]), 32'(pat(12'h348)));
    clr_log();
    bus_acc(1, 1, 2'b10, trig(12'h402), 32'h0500_0400);
    wait_idle(cyc);
    for (k = 0; k < 6; k++)
      chk("R7 upward overlap re-read", 32'(mem[12'h402 + k]), 32'(pat(12'h400 + (k % 2))));
    bus_acc(1, 1, 2'b10, trig(12'h450), 32'h0500_0452);
    wait_idle(cyc);
    for (k = 0; k < 6; k++)
      chk("R7 downward overlap", 32'(mem[12'h450 + k]), 32'(pat(12'h452 + k)));
  endtask

  task automatic t_read();
    int cyc;
    clr_log();
    valid = 1'b1; wr = 1'b0; win = 1'b1; size = 2'b10; addr = trig(12'h700); wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R8 read ready", 32'(ready), 1);
    chk("R8 read data", rdata, 0);
    valid = 1'b0;
    chk("R8 read no busy", 32'(busy), 0);
    wait_idle(cyc);
    chk("R8 read no access", n_wr + n_rd, 0);
  endtask

  task automatic t_size();
    int cyc;
    bus_acc(1, 1, 2'b10, 23'h0, 32'h0000_0042);
    clr_log();
    bus_acc(1, 1, 2'b00, 23'h0, 32'h0000_0099);
    bus_acc(1, 1, 2'b01, trig(12'h800), 32'h00FF_FFFF);
    chk("R9 narrow trigger no busy", 32'(busy), 0);
    wait_idle(cyc);
    chk("R9 narrow no access", n_wr, 0);
    bus_acc(1, 1, 2'b10, trig(12'h800), 32'h00FF_FFFF);
    wait_idle(cyc);
    chk("R9 latch unchanged", 32'(mem[12'h800]), 32'h42);
  endtask

  task automatic t_stall();
    int cyc, k;
    bus_acc(1, 1, 2'b10, 23'h0, 32'h0000_0011);
    bus_acc(1, 1, 2'b10, trig(12'h900), 32'h1FFF_FFFF);
    chk("R10 busy during run", 32'(busy), 1);
    chk("R10 ready low", 32'(ready), 0);
    bus_acc(1, 1, 2'b10, 23'h0, 32'h0000_0077);
    for (k = 0; k < 32; k++) chk("R10 colour held", 32'(mem[12'h900 + k]), 32'h11);
    bus_acc(1, 1, 2'b10, trig(12'h940), 32'h00FF_FFFF);
    wait_idle(cyc);
    chk("R10 queued latch applied", 32'(mem[12'h940]), 32'h77);
  endtask

  task automatic t_wrap();
    int cyc;
    clr_log();
    bus_acc(1, 1, 2'b10, trig(20'hFFFFE), 32'h02FF_FFFF);
    wait_idle(cyc);
    chk("R12 wrap count", n_wr, 3);
    chk("R12 addr0", 32'(wlog[0]), 32'h0FFFFE);
    chk("R12 addr1", 32'(wlog[1]), 32'h0FFFFF);
    chk("R12 addr2", 32'(wlog[2]), 32'h000000);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_only();
    t_stipple();
    t_fill();
    t_copy();
    t_read();
    t_size();
    t_stall();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule